// File: doc/BRIEF.md
# Segment Descriptor Load and Access Check Unit

This block holds one segment register. When a new 16-bit selector is presented, it chooses the global or the local descriptor table, screens the selector against that table, and fetches the 8-byte descriptor as two 32-bit reads over a simple request/response port. The base, the 20-bit limit, the granularity flag and the access byte are unpacked into a shadow cache. The load ends with a one-cycle done pulse and a result code.

Every later access request carries an offset, a size and a kind (read, write or execute). The block checks the request against the cached descriptor and answers one cycle later with either a linear address or a fault code. The cache is a snapshot taken at load time. Writes to table memory after the load have no effect on accesses until the selector is loaded again.

The table base and limit values come in as plain inputs. Privilege comparison is not performed. The requested privilege bits travel with the stored selector.

Top module: `segDescUnit`

## Requirements
- R1: A selector carries the index in bits 15:3, the table choice in bit 2 (0 global, 1 local) and privilege bits in 1:0. A fetch reads exactly two words, the first at table base + 8*index and the second 4 bytes above it, with `memValid` returning each word after its request.
- R2: Global index 0 ends the load with code 1 (null) and no memory read. Local index 0 is an ordinary entry and loads normally.
- R3: If 8*index+7 exceeds the chosen table's byte limit, the load ends with code 2 (bound) and no memory read. The last entry that fits loads normally.
- R4: The fetched words are taken little-endian. Word 0 holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. Word 1 holds base[23:16] in bits 7:0, the access byte in 15:8, limit[19:16] in 19:16, the flags in 23:20 and base[31:24] in 31:24.
- R5: An access byte with bit 4 clear (system type) ends the load with code 3. This check takes precedence over the present check.
- R6: An access byte with bit 7 clear (not present) ends the load with code 4. A successful load reports code 0.
- R7: Accepting a load invalidates the cache at once, and a failed load leaves it invalid. Any access made through an invalid cache returns code 5.
- R8: Flag bit 23 of word 1 (granularity) set makes the effective limit {limit, 12'hFFF}. When it is clear, the effective limit is the 20-bit limit itself.
- R9: An access covers accSize+1 bytes. If offset+accSize exceeds the effective limit, computed without wrap, the response is code 6. Otherwise the response is code 0 with address = base+offset modulo 2^32. A faulting response drives the address to zero.
- R10: Access kind is 0 read, 1 write, 2 execute, 3 read. Writing to a segment with access bit 3 set (executable) returns code 7, and so does executing a segment with bit 3 clear. The kind check takes precedence over the limit check.
- R11: Changes to table memory after a load do not affect accesses until the selector is loaded again.
- R12: Each accepted access gets a response exactly one cycle later. `ldDone` is a single-cycle pulse. `ldValid` is ignored while `ldBusy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldValid | input | 1 | Start a selector load |
| ldSelector | input | 16 | Selector to load |
| ldBusy | output | 1 | Load in progress |
| ldDone | output | 1 | Load finished (one-cycle pulse) |
| ldCode | output | 3 | Result code of the last load |
| globalBase | input | 32 | Global table byte address |
| globalLimit | input | TBL_LIM_W | Global table byte limit |
| localBase | input | 32 | Local table byte address |
| localLimit | input | TBL_LIM_W | Local table byte limit |
| memReq | output | 1 | Word read request |
| memAddr | output | 32 | Word read byte address |
| memValid | input | 1 | Read data valid |
| memData | input | 32 | Read data word |
| accValid | input | 1 | Access request |
| accOffset | input | 32 | Access offset within the segment |
| accKind | input | 2 | Access kind |
| accSize | input | SIZE_W | Access byte count minus one |
| rspValid | output | 1 | Access response valid |
| rspAddr | output | 32 | Linear address, zero on fault |
| rspCode | output | 3 | Access result code |
| segSel | output | 16 | Selector of the cached segment |
| segAttr | output | 12 | Cached flags nibble and access byte |

## Verification
The assertions assume that memory returns data only for a request the block has made, and that no second request is outstanding at that moment. They also assume the table base and limit inputs hold steady while a load is in flight. The bench memory model answers every request exactly one cycle later and never answers unasked, and the table registers are set once before the first load. Load attempts made while a load is busy are driven on purpose, since the block is required to ignore them. Accesses are driven during loads as well, which exercises the rule that an access made then sees an invalidated cache.

// File: rtl/segPkg.sv
package segPkg;
  localparam int LIN_W = 32;
  localparam int SEL_W = 16;
  localparam int IDX_W = 13;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_NULL  = 3'd1,
    FLT_BOUND = 3'd2,
    FLT_SYS   = 3'd3,
    FLT_NOTP  = 3'd4,
    FLT_NOSEG = 3'd5,
    FLT_LIMIT = 3'd6,
    FLT_TYPE  = 3'd7
  } segFaultT;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKindT;

  typedef struct packed {
    logic latchSel;
    logic invalidate;
    logic useHi;
    logic capLo;
    logic capHi;
    logic commit;
  } segStrobeT;
endpackage

// File: rtl/segLoadCtrl.sv
module segLoadCtrl
  import segPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ldValid,
  input  logic       selNull,
  input  logic       selOob,
  input  logic       descSys,
  input  logic       descAbsent,
  input  logic       memValid,
  output segStrobeT  strb,
  output logic       memReq,
  output logic       ldBusy,
  output logic       ldDone,
  output logic [2:0] ldCode
);
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_RD0, ST_RD1, ST_FIN} ldStateT;
  ldStateT state, nxt;

  always_comb begin
    nxt = state;
    strb = '0;
    memReq = 1'b0;
    case (state)
      ST_IDLE: if (ldValid) begin
        strb.latchSel = 1'b1;
        strb.invalidate = 1'b1;
        nxt = ST_CHECK;
      end
      ST_CHECK: if (selNull || selOob) begin
        nxt = ST_IDLE;
      end else begin
        memReq = 1'b1;
        nxt = ST_RD0;
      end
      ST_RD0: if (memValid) begin
        strb.capLo = 1'b1;
        strb.useHi = 1'b1;
        memReq = 1'b1;
        nxt = ST_RD1;
      end
      ST_RD1: if (memValid) begin
        strb.capHi = 1'b1;
        nxt = ST_FIN;
      end
      ST_FIN: begin
        strb.commit = !descSys && !descAbsent;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign ldBusy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ldDone <= 1'b0;
      ldCode <= FLT_NONE;
    end else begin
      state <= nxt;
      ldDone <= 1'b0;
      if (state == ST_CHECK && (selNull || selOob)) begin
        ldDone <= 1'b1;
        ldCode <= selNull ? FLT_NULL : FLT_BOUND;
      end
      if (state == ST_FIN) begin
        ldDone <= 1'b1;
        ldCode <= descSys ? FLT_SYS : (descAbsent ? FLT_NOTP : FLT_NONE);
      end
    end
  end
endmodule

// File: rtl/segDatapath.sv
module segDatapath
  import segPkg::*;
#(
  parameter int TBL_LIM_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  segStrobeT            strb,
  input  logic [SEL_W-1:0]     ldSelector,
  input  logic [LIN_W-1:0]     globalBase,
  input  logic [TBL_LIM_W-1:0] globalLimit,
  input  logic [LIN_W-1:0]     localBase,
  input  logic [TBL_LIM_W-1:0] localLimit,
  input  logic [WORD_W-1:0]    memData,
  input  logic                 accValid,
  input  logic [LIN_W-1:0]     accOffset,
  input  logic [1:0]           accKind,
  input  logic [SIZE_W-1:0]    accSize,
  output logic                 selNull,
  output logic                 selOob,
  output logic                 descSys,
  output logic                 descAbsent,
  output logic [LIN_W-1:0]     memAddr,
  output logic                 rspValid,
  output logic [LIN_W-1:0]     rspAddr,
  output logic [2:0]           rspCode,
  output logic [SEL_W-1:0]     segSel,
  output logic [11:0]          segAttr
);
  localparam int OFF_W = IDX_W + 3;
  localparam int CMP_W = ((OFF_W > TBL_LIM_W) ? OFF_W : TBL_LIM_W) + 1;
  localparam int LIM_W = 20;
  localparam int PAD_W = LIN_W - LIM_W;

  logic [SEL_W-1:0] selQ;
  logic [WORD_W-1:0] loWord, hiWord;

  // Selector decode and table screening
  logic selLocal;
  logic [IDX_W-1:0] selIdx;
  logic [OFF_W-1:0] entryOff;
  logic [CMP_W-1:0] entryEnd;
  logic [LIN_W-1:0] tblBase;
  logic [TBL_LIM_W-1:0] tblLim;

  assign selIdx = selQ[SEL_W-1:3];
  assign selLocal = selQ[2];
  assign entryOff = {selIdx, 3'b000};
  assign entryEnd = CMP_W'(entryOff) + CMP_W'(7);
  assign tblBase = selLocal ? localBase : globalBase;
  assign tblLim = selLocal ? localLimit : globalLimit;
  assign selNull = !selLocal && (selIdx == '0);
  assign selOob = entryEnd > CMP_W'(tblLim);
  assign memAddr = tblBase + LIN_W'(entryOff) + (strb.useHi ? LIN_W'(4) : '0);

  // Descriptor field unpacking
  logic [LIN_W-1:0] dBase;
  logic [LIM_W-1:0] dLimit;
  logic [7:0] dAccess;
  logic [3:0] dFlags;

  assign dBase = {hiWord[31:24], hiWord[7:0], loWord[31:16]};
  assign dLimit = {hiWord[19:16], loWord[15:0]};
  assign dAccess = hiWord[15:8];
  assign dFlags = hiWord[23:20];
  assign descSys = !dAccess[4];
  assign descAbsent = !dAccess[7];

  // Shadow cache
  logic cValid;
  logic [LIN_W-1:0] cBase;
  logic [LIM_W-1:0] cLimit;
  logic [7:0] cAccess;
  logic [3:0] cFlags;
  logic [SEL_W-1:0] cSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      loWord <= '0;
      hiWord <= '0;
      cValid <= 1'b0;
      cBase <= '0;
      cLimit <= '0;
      cAccess <= '0;
      cFlags <= '0;
      cSel <= '0;
    end else begin
      if (strb.latchSel) selQ <= ldSelector;
      if (strb.capLo) loWord <= memData;
      if (strb.capHi) hiWord <= memData;
      if (strb.invalidate) cValid <= 1'b0;
      if (strb.commit) begin
        cValid <= 1'b1;
        cBase <= dBase;
        cLimit <= dLimit;
        cAccess <= dAccess;
        cFlags <= dFlags;
        cSel <= selQ;
      end
    end
  end

  assign segSel = cSel;
  assign segAttr = {cFlags, cAccess};

  // Access check
  logic cGran, cExec;
  logic [LIN_W-1:0] effLim;
  logic [LIN_W:0] accEnd;
  segFaultT accFault;

  assign cGran = cFlags[3];
  assign cExec = cAccess[3];
  assign effLim = cGran ? {cLimit, 12'hFFF} : {{PAD_W{1'b0}}, cLimit};
  assign accEnd = {1'b0, accOffset} + (LIN_W + 1)'(accSize);

  always_comb begin
    accFault = FLT_NONE;
    if (!cValid) accFault = FLT_NOSEG;
    else if ((accKind == ACC_WRITE && cExec) || (accKind == ACC_EXEC && !cExec))
      accFault = FLT_TYPE;
    else if (accEnd > {1'b0, effLim}) accFault = FLT_LIMIT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr <= '0;
      rspCode <= FLT_NONE;
    end else begin
      rspValid <= accValid;
      if (accValid) begin
        rspCode <= accFault;
        rspAddr <= (accFault == FLT_NONE) ? cBase + accOffset : '0;
      end
    end
  end
endmodule

// File: rtl/segDescUnit.sv
module segDescUnit
  import segPkg::*;
#(
  parameter int TBL_LIM_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ldValid,
  input  logic [15:0]          ldSelector,
  output logic                 ldBusy,
  output logic                 ldDone,
  output logic [2:0]           ldCode,
  input  logic [31:0]          globalBase,
  input  logic [TBL_LIM_W-1:0] globalLimit,
  input  logic [31:0]          localBase,
  input  logic [TBL_LIM_W-1:0] localLimit,
  output logic                 memReq,
  output logic [31:0]          memAddr,
  input  logic                 memValid,
  input  logic [31:0]          memData,
  input  logic                 accValid,
  input  logic [31:0]          accOffset,
  input  logic [1:0]           accKind,
  input  logic [SIZE_W-1:0]    accSize,
  output logic                 rspValid,
  output logic [31:0]          rspAddr,
  output logic [2:0]           rspCode,
  output logic [15:0]          segSel,
  output logic [11:0]          segAttr
);
  segStrobeT strb;
  logic selNull, selOob, descSys, descAbsent;

  segLoadCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ldValid(ldValid),
    .selNull(selNull), .selOob(selOob), .descSys(descSys), .descAbsent(descAbsent),
    .memValid(memValid), .strb(strb), .memReq(memReq),
    .ldBusy(ldBusy), .ldDone(ldDone), .ldCode(ldCode)
  );

  segDatapath #(.TBL_LIM_W(TBL_LIM_W), .SIZE_W(SIZE_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .ldSelector(ldSelector),
    .globalBase(globalBase), .globalLimit(globalLimit),
    .localBase(localBase), .localLimit(localLimit),
    .memData(memData), .accValid(accValid), .accOffset(accOffset),
    .accKind(accKind), .accSize(accSize),
    .selNull(selNull), .selOob(selOob), .descSys(descSys), .descAbsent(descAbsent),
    .memAddr(memAddr), .rspValid(rspValid), .rspAddr(rspAddr), .rspCode(rspCode),
    .segSel(segSel), .segAttr(segAttr)
  );
endmodule

// File: rtl/segDescChecker.sv
module segDescChecker #(
  parameter int TBL_LIM_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ldValid,
  input logic [15:0]          ldSelector,
  input logic                 ldBusy,
  input logic                 ldDone,
  input logic [2:0]           ldCode,
  input logic [31:0]          globalBase,
  input logic [TBL_LIM_W-1:0] globalLimit,
  input logic                 memReq,
  input logic [31:0]          memAddr,
  input logic                 accValid,
  input logic                 rspValid,
  input logic [31:0]          rspAddr,
  input logic [2:0]           rspCode
);
  logic [15:0] trkSel;
  logic trkNull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trkSel <= 16'h0004;
    else if (ldValid && !ldBusy) trkSel <= ldSelector;
  end

  assign trkNull = !trkSel[2] && (trkSel[15:3] == 13'd0);

  AST_NULL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    ldDone && trkNull |-> ldCode == 3'd1);  // R2
  AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    ldBusy && trkNull |-> !memReq);  // R2
  AST_READ_IN_TABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !trkSel[2] |-> ({1'b0, memAddr - globalBase} + 33'd3) <= 33'(globalLimit));  // R3
  AST_LOAD_INVALIDATES: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && $past(ldBusy) |-> rspCode == 3'd5);  // R7
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspCode != 3'd0 |-> rspAddr == 32'd0);  // R9
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid);  // R12
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !rspValid);  // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ldDone |=> !ldDone);  // R12
endmodule

bind segDescUnit segDescChecker #(.TBL_LIM_W(TBL_LIM_W)) uChk (
  .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldSelector(ldSelector),
  .ldBusy(ldBusy), .ldDone(ldDone), .ldCode(ldCode),
  .globalBase(globalBase), .globalLimit(globalLimit),
  .memReq(memReq), .memAddr(memAddr), .accValid(accValid),
  .rspValid(rspValid), .rspAddr(rspAddr), .rspCode(rspCode)
);

// File: tb/sim_segDescUnit.sv
`timescale 1ns/1ps
module sim_segDescUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldValid = 1'b0;
  logic [15:0] ldSelector = '0;
  logic ldBusy, ldDone;
  logic [2:0] ldCode;
  logic [31:0] globalBase = 32'h100;
  logic [15:0] globalLimit = 16'h3F;
  logic [31:0] localBase = 32'h200;
  logic [15:0] localLimit = 16'h1F;
  logic memReq;
  logic [31:0] memAddr;
  logic memValid = 1'b0;
  logic [31:0] memData = '0;
  logic accValid = 1'b0;
  logic [31:0] accOffset = '0;
  logic [1:0] accKind = '0;
  logic [2:0] accSize = '0;
  logic rspValid;
  logic [31:0] rspAddr;
  logic [2:0] rspCode;
  logic [15:0] segSel;
  logic [11:0] segAttr;

  always #2 clk = ~clk;

  segDescUnit u0 (.*);

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    memValid <= memReq;
    memData <= mem[memAddr[9:2]];
  end

  int vectors = 0;
  int errors = 0;
  int reqCnt = 0;
  int doneCnt = 0;
  logic [31:0] firstAddr = '0, secondAddr = '0;
  logic accSeen = 1'b0;

  // reference cache
  bit refValid = 0;
  logic [31:0] refBase = '0;
  longint refEff = 0;
  bit refExec = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) accSeen <= accValid;
  always @(negedge clk) if (rstN) begin
    if (memReq) begin
      if (reqCnt == 0) firstAddr = memAddr; else secondAddr = memAddr;
      reqCnt++;
    end
    if (ldDone) doneCnt++;
    check(rspValid == accSeen, "R12", "rspValid per clock", rspValid, accSeen);
  end

  task automatic putDesc(input logic [31:0] tbl, input int idx, input logic [31:0] base,
                         input logic [19:0] lim, input logic [7:0] acc, input logic [3:0] flg);
    int w;
    w = (tbl + idx * 8) >> 2;
    mem[w] = {base[15:0], lim[15:0]};
    mem[w + 1] = {base[31:24], flg, lim[19:16], acc, base[23:16]};
  endtask

  task automatic doLoad(input logic [15:0] sel, input bit extra, input logic [15:0] sel2,
                        input string req);
    int idx;
    bit loc;
    logic [31:0] tb, w0, w1, ent;
    longint lim;
    logic [2:0] exp;
    int expReads, spins;
    idx = int'(sel[15:3]);
    loc = sel[2];
    tb = loc ? localBase : globalBase;
    lim = loc ? longint'(localLimit) : longint'(globalLimit);
    ent = tb + 32'(idx * 8);
    w0 = mem[ent[9:2]];
    w1 = mem[ent[9:2] + 8'd1];
    if (!loc && idx == 0) exp = 3'd1;
    else if (longint'(idx) * 8 + 7 > lim) exp = 3'd2;
    else if (!w1[12]) exp = 3'd3;
    else if (!w1[15]) exp = 3'd4;
    else exp = 3'd0;
    expReads = (exp == 3'd1 || exp == 3'd2) ? 0 : 2;
    @(negedge clk);
    reqCnt = 0;
    doneCnt = 0;
    ldSelector = sel;
    ldValid = 1'b1;
    @(negedge clk);
    ldValid = 1'b0;
    if (extra) begin
      ldSelector = sel2;
      ldValid = 1'b1;
      @(negedge clk);
      ldValid = 1'b0;
    end
    spins = 0;
    while (!ldDone && spins < 20) begin
      @(negedge clk);
      spins++;
    end
    check(ldDone == 1'b1, req, "load done seen", ldDone, 1);
    check(ldCode == exp, req, "load code", ldCode, exp);
    check(reqCnt == expReads, "R1", "read count", reqCnt, expReads);
    if (expReads == 2) begin
      check(firstAddr == ent, "R1", "first read address", firstAddr, ent);
      check(secondAddr == ent + 4, "R1", "second read address", secondAddr, ent + 4);
    end
    refValid = (exp == 3'd0);
    if (exp == 3'd0) begin
      refBase = {w1[31:24], w1[7:0], w0[31:16]};
      lim = longint'({w1[19:16], w0[15:0]});
      refEff = w1[23] ? (lim << 12) + 4095 : lim;
      refExec = w1[11];
      check(segSel == sel, "R4", "stored selector", segSel, sel);
    end
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R12", "single done pulse", doneCnt, 1);
  endtask

  task automatic doAcc(input logic [31:0] off, input logic [1:0] kind, input logic [2:0] sz,
                       input string req);
    logic [2:0] exp;
    logic [31:0] expAddr;
    exp = 3'd0;
    expAddr = '0;
    if (!refValid) exp = 3'd5;
    else if ((kind == 2'd1 && refExec) || (kind == 2'd2 && !refExec)) exp = 3'd7;
    else if (longint'(off) + longint'(sz) > refEff) exp = 3'd6;
    else expAddr = refBase + off;
    @(negedge clk);
    accOffset = off;
    accKind = kind;
    accSize = sz;
    accValid = 1'b1;
    @(negedge clk);
    accValid = 1'b0;
    check(rspCode == exp, req, "access code", rspCode, exp);
    check(rspAddr == expAddr, req, "access address", rspAddr, expAddr);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    putDesc(32'h100, 1, 32'h1000_0000, 20'hFFFFF, 8'h9A, 4'hC);
    putDesc(32'h100, 2, 32'h0000_5000, 20'h00100, 8'h89, 4'h0);
    putDesc(32'h100, 3, 32'h0000_6000, 20'h00100, 8'h12, 4'h0);
    putDesc(32'h100, 4, 32'h0020_0000, 20'h00001, 8'h92, 4'h8);
    putDesc(32'h100, 7, 32'h0004_0000, 20'h00FFF, 8'h92, 4'h4);
    putDesc(32'h200, 0, 32'hABCD_1200, 20'h000FF, 8'h92, 4'h4);
    putDesc(32'h200, 3, 32'h7700_0000, 20'h0000F, 8'h9A, 4'h4);
    repeat (3) @(negedge clk);
    check(ldBusy == 0 && ldDone == 0 && rspValid == 0, "R12", "reset outputs",
          {ldBusy, ldDone, rspValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    doAcc(32'h10, 2'd0, 3'd0, "R7");
    doLoad(16'h0000, 0, 0, "R2");
    doAcc(32'h10, 2'd0, 3'd0, "R7");
    doLoad(16'h0040, 0, 0, "R3");
    doLoad(16'h0008, 0, 0, "R4");
    doAcc(32'h0000_1234, 2'd2, 3'd0, "R4");
    doAcc(32'h0000_1234, 2'd1, 3'd0, "R10");
    doAcc(32'h0000_0010, 2'd3, 3'd1, "R10");
    doAcc(32'hFFFF_FFFC, 2'd0, 3'd3, "R8");
    doAcc(32'hFFFF_FFFD, 2'd0, 3'd3, "R9");
    doLoad(16'h003B, 0, 0, "R3");
    doAcc(32'h0000_0FFF, 2'd1, 3'd0, "R9");
    doAcc(32'h0000_0FFE, 2'd1, 3'd1, "R9");
    doAcc(32'h0000_0FFF, 2'd1, 3'd1, "R9");
    doAcc(32'h0000_0000, 2'd2, 3'd0, "R10");
    putDesc(32'h100, 7, 32'h0009_0000, 20'h00FFF, 8'h92, 4'h4);
    doAcc(32'h0000_0020, 2'd0, 3'd0, "R11");
    check(rspAddr == 32'h0004_0020, "R11", "old base kept", rspAddr, 32'h0004_0020);
    doLoad(16'h0038, 0, 0, "R11");
    doAcc(32'h0000_0020, 2'd0, 3'd0, "R11");
    doLoad(16'h0020, 0, 0, "R8");
    doAcc(32'h0000_1FFF, 2'd0, 3'd0, "R8");
    doAcc(32'h0000_2000, 2'd0, 3'd0, "R8");
    doLoad(16'h0010, 0, 0, "R5");
    doAcc(32'h0, 2'd0, 3'd0, "R7");
    doLoad(16'h0018, 0, 0, "R6");
    doAcc(32'h0, 2'd0, 3'd0, "R7");
    doLoad(16'h0007, 0, 0, "R2");
    doAcc(32'h0000_00FF, 2'd1, 3'd0, "R2");
    check(segAttr == 12'h492, "R4", "cached attributes", segAttr, 12'h492);
    doLoad(16'h0024, 0, 0, "R3");
    doLoad(16'h001C, 0, 0, "R3");
    doAcc(32'h0000_000F, 2'd2, 3'd0, "R3");
    doLoad(16'h0008, 1, 16'h0010, "R12");
    doAcc(32'h0000_0100, 2'd2, 3'd0, "R12");
    // access during a load sees an invalid cache
    @(negedge clk);
    ldSelector = 16'h0038;
    ldValid = 1'b1;
    @(negedge clk);
    ldValid = 1'b0;
    refValid = 0;
    doAcc(32'h0, 2'd2, 3'd0, "R7");
    repeat (10) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog got=hang exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule